// File: doc/BRIEF.md
# Flow-Through SECDED Corrector for a 16-Bit Memory Word

This block checks and repairs a 16-bit word read from memory together with its stored check bits. It regenerates the check bits from the incoming data through a set of XOR trees and XORs them with the stored bits to form a syndrome. It then sorts the result into one of five outcomes: clean, single data-bit error, single check-bit error, double error or multi-bit error. The outcome is reported on two active-low flags and on a class code.

A run-time width select picks one of two syndrome codes. The wide code uses eight check bits. The narrow code uses six check bits, and every data column in it has exactly three ones. A correction enable decides whether a single data-bit error is inverted in the output word. Check-bit errors are reported and never repaired.

The same XOR trees serve the write path. When a word is presented, the generated check bits for that word come out alongside it. All outputs pass through one register stage.

Top module: `secded16_corrector`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next outputs are `data_out`=0, `check_out`=0, `ce_n`=1, `ue_n`=1 and `err_class`=0.
- R2: Every output reflects the inputs sampled at the previous rising edge (one register stage); it does not change between edges.
- R3: A zero syndrome gives class 0 (clean). Both flags are high and `data_out` equals `data_in`. Class 0 is reported exactly when both flags are high.
- R4: With `narrow_mode`=0, the syndrome naming data bit i is, for i = 0..15: 0x0D, 0xCE, 0xDC, 0xAC, 0x4B, 0xD5, 0x23, 0x71, 0x53, 0x16, 0x1A, 0xF2, 0xA5, 0xE9, 0x2A, 0xB4.
- R5: A syndrome with only bit k set gives class 2 (check-bit error). `ce_n` goes low, `ue_n` stays high, and the data is never altered.
- R6: A syndrome naming data bit i gives class 1 and drives `ce_n` low. With `corr_en`=1, bit i of `data_out` is inverted. The output never differs from the input in more than one bit, and never without `ce_n` low.
- R7: With `corr_en`=0, `data_out` equals `data_in` for every syndrome, while the class and flags still report the result.
- R8: A nonzero syndrome that is neither a single column but equals the XOR of two distinct code columns (data or check) gives class 3 (double). `ue_n` goes low and the data passes through unmodified.
- R9: Any other nonzero syndrome gives class 4 (multi). `ue_n` goes low and the data passes through unmodified.
- R10: With `narrow_mode`=1, syndrome bits 7:6 are forced to zero, so stored check bits 7:6 are ignored. The data columns for bits 0..15 are 0x07, 0x0B, 0x1C, 0x0D, 0x0E, 0x13, 0x15, 0x16, 0x19, 0x1A, 0x23, 0x25, 0x26, 0x29, 0x2A, 0x2C.
- R11: `check_out` holds, for the current mode, the check bits generated from `data_in`. Bit k is the XOR of the data bits whose column has a one at position k. In narrow mode, bits 7:6 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| narrow_mode | input | 1 | 0: 8-bit syndrome, 1: 6-bit syndrome |
| corr_en | input | 1 | Enables inversion of a single erroneous data bit |
| data_in | input | 16 | Data word read from memory, or word to be written |
| check_in | input | 8 | Stored check bits read with the word |
| data_out | output | 16 | Registered data word, corrected when enabled |
| check_out | output | 8 | Registered check bits generated from `data_in` |
| ce_n | output | 1 | Low for a single-bit (correctable) error |
| ue_n | output | 1 | Low for a double or multi-bit error |
| err_class | output | 3 | 0 clean, 1 data bit, 2 check bit, 3 double, 4 multi |

## Verification
Each test word is encoded by the bench's own column tables and then corrupted with explicit data and check flip masks, in both syndrome widths.

- **Clean words** separate a pass-through from a spurious repair.
- **Single data flips** at low, middle and top positions, with correction on and off, confirm both the column table and the enable gating.
- **Single check flips** show a flag with no data change. A flip of an upper check bit in narrow mode shows that bit is ignored.
- **Data-data and data-check pairs** exercise the double rule. Syndromes 0x07 (wide) and 0x1F (narrow) fall into neither the single nor the pair set and so exercise the multi class.
- **Literal check words** for a lone data bit pin the write path in each mode.

// File: rtl/secded16_pkg.sv
// Package: code tables and shared types of the 16-bit SECDED corrector.
// Assumes a 16-bit data word and up to 8 check bits; the narrow code uses
// only check positions 0..5.
package secded16_pkg;

    localparam int DW       = 16;          // data bits
    localparam int CW       = 8;           // check bits, wide code
    localparam int NW       = 6;           // check bits, narrow code
    localparam int NCOL     = DW + CW;     // columns of the code matrix
    localparam int CLS_W    = 3;           // width of the class code

    typedef enum logic [CLS_W-1:0] {
        CLS_NONE   = 3'd0,
        CLS_DATA   = 3'd1,
        CLS_CHECK  = 3'd2,
        CLS_DOUBLE = 3'd3,
        CLS_MULTI  = 3'd4
    } err_cls_e;

    // Column of data bit i in the 8-bit code.
    function automatic logic [CW-1:0] wide_col(input int unsigned i);
        case (i)
            0:  return 8'h0D;
            1:  return 8'hCE;
            2:  return 8'hDC;
            3:  return 8'hAC;
            4:  return 8'h4B;
            5:  return 8'hD5;
            6:  return 8'h23;
            7:  return 8'h71;
            8:  return 8'h53;
            9:  return 8'h16;
            10: return 8'h1A;
            11: return 8'hF2;
            12: return 8'hA5;
            13: return 8'hE9;
            14: return 8'h2A;
            15: return 8'hB4;
            default: return '0;
        endcase
    endfunction

    // Column of data bit i in the 6-bit code (all of weight three).
    function automatic logic [CW-1:0] narrow_col(input int unsigned i);
        case (i)
            0:  return 8'h07;
            1:  return 8'h0B;
            2:  return 8'h1C;
            3:  return 8'h0D;
            4:  return 8'h0E;
            5:  return 8'h13;
            6:  return 8'h15;
            7:  return 8'h16;
            8:  return 8'h19;
            9:  return 8'h1A;
            10: return 8'h23;
            11: return 8'h25;
            12: return 8'h26;
            13: return 8'h29;
            14: return 8'h2A;
            15: return 8'h2C;
            default: return '0;
        endcase
    endfunction

    // Column i of the full matrix: data columns first, then unit check columns.
    // A check column outside the active code width is zero.
    function automatic logic [CW-1:0] column(input int unsigned i, input logic narrow);
        int unsigned k;
        if (i < DW) begin
            return narrow ? narrow_col(i) : wide_col(i);
        end
        k = i - DW;
        if (narrow && (k >= NW)) begin
            return '0;
        end
        return CW'(1) << k;
    endfunction

    // Data bits feeding check bit k.
    function automatic logic [DW-1:0] tree_mask(input int unsigned k, input logic narrow);
        logic [DW-1:0] m;
        logic [CW-1:0] c;
        m = '0;
        for (int unsigned i = 0; i < DW; i++) begin
            c    = column(i, narrow);
            m[i] = c[k];
        end
        return m;
    endfunction

endpackage

// File: rtl/secded16_parity_gen.sv
// Module: XOR trees that produce the check bits of a data word.
// Assumes: both code widths share the trees; the mode selects the mask
// of each tree, so narrow-mode bits above NW come out zero.
module secded16_parity_gen
    import secded16_pkg::*;
(
    input  logic [DW-1:0] data,
    input  logic          narrow,
    output logic [CW-1:0] check
);

    generate
        for (genvar k = 0; k < CW; k++) begin : g_tree
            localparam logic [DW-1:0] MASK_W = tree_mask(k, 1'b0);
            localparam logic [DW-1:0] MASK_N = tree_mask(k, 1'b1);
            // One parity tree per check bit, mask chosen by the mode.
            assign check[k] = ^(data & (narrow ? MASK_N : MASK_W));
        end
    endgenerate

endmodule

// File: rtl/secded16_syn_decode.sv
// Module: classifies a syndrome and names the data bit to flip.
// Assumes: the syndrome is already masked to the active code width.
// Priority: zero, single data column, single check column, pair, multi.
module secded16_syn_decode
    import secded16_pkg::*;
(
    input  logic [CW-1:0] syndrome,
    input  logic          narrow,
    output err_cls_e      cls,
    output logic [DW-1:0] flip
);

    logic          hit_data;
    logic          hit_chk;
    logic          hit_pair;
    logic [CW-1:0] col_a;
    logic [CW-1:0] col_b;

    // Compare the syndrome with every column and every column pair.
    always_comb begin
        hit_data = 1'b0;
        hit_chk  = 1'b0;
        hit_pair = 1'b0;
        flip     = '0;
        col_a    = '0;
        col_b    = '0;
        for (int unsigned i = 0; i < DW; i++) begin
            col_a = column(i, narrow);
            if (col_a == syndrome) begin
                hit_data = 1'b1;
                flip[i]  = 1'b1;
            end
        end
        for (int unsigned k = 0; k < CW; k++) begin
            col_a = column(DW + k, narrow);
            if ((col_a != '0) && (col_a == syndrome)) begin
                hit_chk = 1'b1;
            end
        end
        for (int unsigned i = 0; i < NCOL; i++) begin
            for (int unsigned j = i + 1; j < NCOL; j++) begin
                col_a = column(i, narrow);
                col_b = column(j, narrow);
                if ((col_a != '0) && (col_b != '0) && ((col_a ^ col_b) == syndrome)) begin
                    hit_pair = 1'b1;
                end
            end
        end
    end

    // Resolve the hits into one class by priority.
    always_comb begin
        if (syndrome == '0)   cls = CLS_NONE;
        else if (hit_data)    cls = CLS_DATA;
        else if (hit_chk)     cls = CLS_CHECK;
        else if (hit_pair)    cls = CLS_DOUBLE;
        else                  cls = CLS_MULTI;
    end

endmodule

// File: rtl/secded16_word_fix.sv
// Module: applies the single-bit repair to the data word.
// Assumes: flip has at most one bit set and only for a data-bit class.
module secded16_word_fix
    import secded16_pkg::*;
(
    input  logic [DW-1:0] data_in,
    input  logic [DW-1:0] flip,
    input  err_cls_e      cls,
    input  logic          corr_en,
    output logic [DW-1:0] data_out
);

    logic repair;

    // Repair only a named data bit, and only when enabled.
    always_comb begin
        repair   = corr_en && (cls == CLS_DATA);
        data_out = repair ? (data_in ^ flip) : data_in;
    end

endmodule

// File: rtl/secded16_corrector.sv
// Module: top of the flow-through SECDED corrector.
// Regenerates check bits, forms and classifies the syndrome, repairs a
// single data bit on request and registers all results once.
// Assumes: synchronous active-low reset; inputs are stable around the edge.
module secded16_corrector
    import secded16_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             narrow_mode,
    input  logic             corr_en,
    input  logic [DW-1:0]    data_in,
    input  logic [CW-1:0]    check_in,
    output logic [DW-1:0]    data_out,
    output logic [CW-1:0]    check_out,
    output logic             ce_n,
    output logic             ue_n,
    output logic [CLS_W-1:0] err_class
);

    localparam logic [CW-1:0] MASK_NARROW = {{(CW-NW){1'b0}}, {NW{1'b1}}};

    logic [CW-1:0] gen_chk;
    logic [CW-1:0] syndrome;
    err_cls_e      cls;
    logic [DW-1:0] flip;
    logic [DW-1:0] fixed;

    secded16_parity_gen u_gen (
        .data   (data_in),
        .narrow (narrow_mode),
        .check  (gen_chk)
    );

    // Syndrome limited to the active code width.
    always_comb begin
        syndrome = (gen_chk ^ check_in) & (narrow_mode ? MASK_NARROW : {CW{1'b1}});
    end

    secded16_syn_decode u_dec (
        .syndrome (syndrome),
        .narrow   (narrow_mode),
        .cls      (cls),
        .flip     (flip)
    );

    secded16_word_fix u_fix (
        .data_in  (data_in),
        .flip     (flip),
        .cls      (cls),
        .corr_en  (corr_en),
        .data_out (fixed)
    );

    // Output register stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out  <= '0;
            check_out <= '0;
            ce_n      <= 1'b1;
            ue_n      <= 1'b1;
            err_class <= CLS_NONE;
        end else begin
            data_out  <= fixed;
            check_out <= gen_chk;
            ce_n      <= !((cls == CLS_DATA) || (cls == CLS_CHECK));
            ue_n      <= !((cls == CLS_DOUBLE) || (cls == CLS_MULTI));
            err_class <= cls;
        end
    end

    // R7
    corr_off_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !corr_en |=> (data_out == $past(data_in)));

    // R8 R9
    ue_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ue_n || (data_out == $past(data_in))));

    // R6
    single_flip_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((data_out == $past(data_in)) ||
                  (!ce_n && ($countones(data_out ^ $past(data_in)) == 1))));

    // R10
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        narrow_mode |=> (check_out[CW-1:NW] == '0));

    // R3
    clean_iff_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_class == CLS_NONE) == (ce_n && ue_n)));

endmodule

// File: tb/test_secded16_corrector.sv
module test_secded16_corrector;

    typedef struct packed {
        logic [15:0] data;
        logic [15:0] derr;
        logic [7:0]  cerr;
        logic        nar;
        logic        corr;
        logic [2:0]  cls;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{16'hA5A5, 16'h0000, 8'h00, 1'b0, 1'b1, 3'd0, 4'd3},   // R3 clean
        '{16'h1234, 16'h0001, 8'h00, 1'b0, 1'b1, 3'd1, 4'd6},   // R6 data bit 0
        '{16'hFFFF, 16'h8000, 8'h00, 1'b0, 1'b1, 3'd1, 4'd4},   // R4 data bit 15
        '{16'h0F0F, 16'h0080, 8'h00, 1'b0, 1'b0, 3'd1, 4'd7},   // R7 no repair
        '{16'h8001, 16'h0000, 8'h08, 1'b0, 1'b1, 3'd2, 4'd5},   // R5 check bit 3
        '{16'h5555, 16'h0000, 8'h80, 1'b0, 1'b1, 3'd2, 4'd5},   // R5 check bit 7
        '{16'h1234, 16'h0003, 8'h00, 1'b0, 1'b1, 3'd3, 4'd8},   // R8 data pair
        '{16'h0000, 16'h0008, 8'h01, 1'b0, 1'b1, 3'd3, 4'd8},   // R8 data+check
        '{16'hABCD, 16'h0000, 8'h07, 1'b0, 1'b1, 3'd4, 4'd9},   // R9 syndrome 0x07
        '{16'h2222, 16'h0004, 8'h00, 1'b1, 1'b1, 3'd1, 4'd10},  // R10 data bit 2
        '{16'hC3C3, 16'h0200, 8'h00, 1'b1, 1'b0, 3'd1, 4'd7},   // R7 narrow, no repair
        '{16'h7E7E, 16'h0000, 8'h20, 1'b1, 1'b1, 3'd2, 4'd5},   // R5 narrow check bit 5
        '{16'h1111, 16'h0000, 8'h80, 1'b1, 1'b1, 3'd0, 4'd10},  // R10 upper bit ignored
        '{16'h9999, 16'h0810, 8'h00, 1'b1, 1'b1, 3'd3, 4'd8},   // R8 narrow pair
        '{16'h3C3C, 16'h0000, 8'h1F, 1'b1, 1'b1, 3'd4, 4'd9},   // R9 syndrome 0x1F
        '{16'hBEEF, 16'h4000, 8'h00, 1'b0, 1'b1, 3'd1, 4'd4},   // R4 data bit 14
        '{16'h0000, 16'h0000, 8'h00, 1'b1, 1'b1, 3'd0, 4'd11}   // R11 zero word
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        narrow_mode = 1'b0;
    logic        corr_en = 1'b0;
    logic [15:0] data_in = '0;
    logic [7:0]  check_in = '0;
    logic [15:0] data_out;
    logic [7:0]  check_out;
    logic        ce_n;
    logic        ue_n;
    logic [2:0]  err_class;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    secded16_corrector i_secded16_corrector (
        .clk         (clk),
        .rst_n       (rst_n),
        .narrow_mode (narrow_mode),
        .corr_en     (corr_en),
        .data_in     (data_in),
        .check_in    (check_in),
        .data_out    (data_out),
        .check_out   (check_out),
        .ce_n        (ce_n),
        .ue_n        (ue_n),
        .err_class   (err_class)
    );

    function automatic logic [7:0] bcol(input int i, input logic nar);
        logic [7:0] w [16] = '{8'h0D, 8'hCE, 8'hDC, 8'hAC, 8'h4B, 8'hD5, 8'h23, 8'h71,
                               8'h53, 8'h16, 8'h1A, 8'hF2, 8'hA5, 8'hE9, 8'h2A, 8'hB4};
        logic [7:0] n [16] = '{8'h07, 8'h0B, 8'h1C, 8'h0D, 8'h0E, 8'h13, 8'h15, 8'h16,
                               8'h19, 8'h1A, 8'h23, 8'h25, 8'h26, 8'h29, 8'h2A, 8'h2C};
        return nar ? n[i] : w[i];
    endfunction

    function automatic logic [7:0] encode(input logic [15:0] d, input logic nar);
        logic [7:0] c = '0;
        for (int i = 0; i < 16; i++) begin
            if (d[i]) c = c ^ bcol(i, nar);
        end
        return c;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] d, input logic [7:0] c, input logic nar,
                         input logic corr);
        data_in     = d;
        check_in    = c;
        narrow_mode = nar;
        corr_en     = corr;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        // R1: reset state with a dirty input present
        apply(16'hFFFF, 8'hAA, 1'b0, 1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "data_out", 32'(data_out), 32'h0);
        chk("R1", "check_out", 32'(check_out), 32'h0);
        chk("R1", "ce_n", 32'(ce_n), 32'h1);
        chk("R1", "ue_n", 32'(ue_n), 32'h1);
        chk("R1", "err_class", 32'(err_class), 32'h0);
        rst_n = 1'b1;

        // Vector table
        for (int v = 0; v < NV; v++) begin
            vec_t t = VECS[v];
            string tag = $sformatf("R%0d", t.req);
            logic [15:0] rd = t.data ^ t.derr;
            logic [15:0] exp_d = (t.corr && t.cls == 3'd1) ? t.data : rd;
            apply(rd, encode(t.data, t.nar) ^ t.cerr, t.nar, t.corr);
            @(posedge clk);
            @(negedge clk);
            chk(tag, "data_out", 32'(data_out), 32'(exp_d));
            chk(tag, "check_out", 32'(check_out), 32'(encode(rd, t.nar)));
            chk(tag, "err_class", 32'(err_class), 32'(t.cls));
            chk(tag, "ce_n", 32'(ce_n), 32'(!(t.cls == 3'd1 || t.cls == 3'd2)));
            chk(tag, "ue_n", 32'(ue_n), 32'(!(t.cls == 3'd3 || t.cls == 3'd4)));
        end

        // R11: write path literal check words for a lone data bit 0
        apply(16'h0001, 8'h00, 1'b0, 1'b1);
        @(posedge clk);
        @(negedge clk);
        chk("R11", "wide check_out", 32'(check_out), 32'h0D);
        apply(16'h0001, 8'h00, 1'b1, 1'b1);
        @(posedge clk);
        @(negedge clk);
        chk("R11", "narrow check_out", 32'(check_out), 32'h07);

        // R2: output holds between edges, updates at the next edge
        apply(16'h00F0, encode(16'h00F0, 1'b0), 1'b0, 1'b1);
        @(posedge clk);
        @(negedge clk);
        apply(16'h0F00, encode(16'h0F00, 1'b0), 1'b0, 1'b1);
        #1;
        chk("R2", "data_out before edge", 32'(data_out), 32'h00F0);
        @(posedge clk);
        @(negedge clk);
        chk("R2", "data_out after edge", 32'(data_out), 32'h0F00);

        // R1: reset in mid-run clears an error report
        apply(16'h1234, encode(16'h1234, 1'b0) ^ 8'h07, 1'b0, 1'b1);
        @(posedge clk);
        @(negedge clk);
        chk("R9", "ue_n before reset", 32'(ue_n), 32'h0);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "ue_n after reset", 32'(ue_n), 32'h1);
        chk("R1", "err_class after reset", 32'(err_class), 32'h0);
        chk("R1", "data_out after reset", 32'(data_out), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule